// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. Its command side takes one request at a time through a valid/ready handshake. A request is one of: program a word, erase one sector, erase the whole array, enable the boot-area write lock, or read the two identification words. For each request the sequencer drives chip enable, write enable, output enable, the address and a 16-bit data driver to issue the unlock write burst that belongs to the command. Each burst begins with the AA/55 key pair at the two magic addresses.

Once the burst of a program, erase or lock command is written, the sequencer reads the request address again and again. It watches bit 6 of each read. While the flash is busy that bit flips from one read to the next. Two successive reads with the same bit 6 mean the operation has finished. If the bit is still changing after a configured number of comparisons, the sequencer reports an error instead. The identification request enters the ID mode, reads offsets 0 and 1, and leaves the mode with an exit burst.

Write pulse widths, read strobe widths and gaps are set as counts of clock cycles through parameters, so the same block fits any clock rate. The reset input is asynchronous and active low, and it is expected to be released synchronously to the clock.

Top module: `nvm_cmd_sequencer`

## Requirements
- R1: Every bus write holds chip enable low and output enable high. Write enable stays low for at least WE_LO_CYC cycles and high for at least WE_HI_CYC cycles between pulses. Address and data stay unchanged while write enable is low and at its rising edge.
- R2: Program (op code 0) issues exactly four writes: AA to 5555h, 55 to 2AAAh, A0 to 5555h, then req_wdata to req_addr. Command data bits 15:8 are zero and command addresses are zero above bit 14.
- R3: Sector erase (1), chip erase (2) and boot lock (3) each issue six writes: AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh. The sixth write is 30 to req_addr for sector erase, 10 to 5555h for chip erase, or 40 to 5555h for lock.
- R4: After the burst of ops 0 to 3, status reads are made at req_addr only, with write enable high. Output enable is low for at least RD_CYC cycles per read and high for at least OE_HI_CYC cycles between reads.
- R5: The first status read whose bit 6 equals bit 6 of the previous read ends the operation with rsp_valid and rsp_err low, and no further read is made.
- R6: If TMO_LIMIT successive comparisons all show bit 6 changed, the operation ends with rsp_err high after exactly TMO_LIMIT+1 status reads.
- R7: Read ID (4) writes AA@5555h, 55@2AAAh, 90@5555h, then reads address 0 into rsp_id0 and address 1 into rsp_id1. It then writes AA@5555h, 55@2AAAh, F0@5555h and ends without error.
- R8: req_ready is high only when idle. req_valid while busy has no effect. rsp_valid is a single-cycle pulse, after which the block is idle again.
- R9: Op codes 5 to 7 end with rsp_err high on the cycle after acceptance, with no bus cycle.
- R10: During and right after reset, chip enable, write enable and output enable are high, the data driver is off, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Idle, request can be taken |
| req_op | input | 3 | 0 program, 1 sector erase, 2 chip erase, 3 boot lock, 4 read ID |
| req_addr | input | AW | Target word or sector address, also the polling address |
| req_wdata | input | 16 | Word to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout or bad op code, valid with rsp_valid |
| rsp_id0 | output | 16 | ID word at offset 0 |
| rsp_id1 | output | 16 | ID word at offset 1 |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash word address |
| fl_dq_out | output | 16 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_in | input | 16 | Data read from the flash |

## Verification
The case that is hardest to reach from the ports is the edge of the timeout. Here the toggling stops either on the very last comparison allowed, or one comparison too late. The bench's flash responder flips bit 6 on each of the first K status reads and then holds it. The bench works out, from K alone, how many reads the operation needs and whether the limit is passed. It runs directed values of K that just meet and just miss the limit, plus random K, with the limit shortened to 8. A second corner, a request held valid for a whole busy operation, is driven directly and must leave neither a second burst nor a raised ready.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    OP_PROG  = 3'd0,
    OP_ESEC  = 3'd1,
    OP_ECHIP = 3'd2,
    OP_LOCK  = 3'd3,
    OP_ID    = 3'd4
  } op_t;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RD, S_RHI, S_RESP} state_t;

  // what to do when the output-enable gap after a read ends
  typedef enum logic [1:0] {A_READ, A_WRITE, A_OK, A_ERR} after_t;

  typedef struct packed {
    logic        tgt_a;  // use the request address
    logic        tgt_d;  // use the request data
    logic [14:0] a;
    logic [7:0]  d;
  } step_t;

  localparam logic [14:0] ADR_P     = 15'h5555;
  localparam logic [14:0] ADR_Q     = 15'h2AAA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_SETUP = 8'h80;
  localparam logic [7:0]  CMD_IDIN  = 8'h90;
  localparam logic [7:0]  CMD_IDOUT = 8'hF0;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_LOCK  = 8'h40;

  // index of the final write in a burst
  function automatic logic [2:0] last_step(op_t op);
    case (op)
      OP_PROG: return 3'd3;
      OP_ID:   return 3'd2;
      default: return 3'd5;
    endcase
  endfunction

  // one write of the unlock burst; ext selects the ID exit burst
  function automatic step_t burst_step(op_t op, logic [2:0] idx, logic ext);
    step_t s;
    s.tgt_a = 1'b0;
    s.tgt_d = 1'b0;
    s.a     = ADR_P;
    s.d     = KEY_1;
    case (idx)
      3'd0: s.d = KEY_1;
      3'd1, 3'd4: begin
        s.a = ADR_Q;
        s.d = KEY_2;
      end
      3'd2: begin
        case (op)
          OP_PROG: s.d = CMD_PROG;
          OP_ID:   s.d = ext ? CMD_IDOUT : CMD_IDIN;
          default: s.d = CMD_SETUP;
        endcase
      end
      3'd3: begin
        if (op == OP_PROG) begin
          s.tgt_a = 1'b1;
          s.tgt_d = 1'b1;
        end
      end
      default: begin
        case (op)
          OP_ESEC: begin
            s.tgt_a = 1'b1;
            s.d     = CMD_SECT;
          end
          OP_LOCK: s.d = CMD_LOCK;
          default: s.d = CMD_CHIP;
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nvm_seq_timer.sv
module nvm_seq_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvm_seq_poll.sv
module nvm_seq_poll #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic bit6,
  output logic stable,
  output logic at_limit
);

  localparam int CW = $clog2(LIMIT + 1);

  logic          have_q, have_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] cmp_q, cmp_d;

  assign stable   = have_q && (bit6 == prev_q);
  assign at_limit = have_q && (cmp_q == CW'(LIMIT - 1));

  always_comb begin
    have_d = have_q;
    prev_d = prev_q;
    cmp_d  = cmp_q;
    if (clear) begin
      have_d = 1'b0;
      cmp_d  = '0;
    end else if (sample) begin
      have_d = 1'b1;
      prev_d = bit6;
      if (have_q) cmp_d = cmp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      cmp_q  <= '0;
    end else begin
      have_q <= have_d;
      prev_q <= prev_d;
      cmp_q  <= cmp_d;
    end
  end

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q <= CW'(LIMIT));

endmodule

// File: rtl/nvm_cmd_sequencer.sv
module nvm_cmd_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int AW        = 18,
  parameter int WE_LO_CYC = 10,
  parameter int WE_HI_CYC = 10,
  parameter int RD_CYC    = 6,
  parameter int OE_HI_CYC = 8,
  parameter int TMO_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [15:0]   rsp_id0,
  output logic [15:0]   rsp_id1,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [15:0]   fl_dq_in
);

  localparam int MAX_AB = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
  localparam int MAX_CD = (RD_CYC > OE_HI_CYC) ? RD_CYC : OE_HI_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW     = $clog2(MAXC + 1);
  localparam logic [TW-1:0] T_WLO = TW'(WE_LO_CYC - 1);
  localparam logic [TW-1:0] T_WHI = TW'(WE_HI_CYC - 1);
  localparam logic [TW-1:0] T_RD  = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] T_RHI = TW'(OE_HI_CYC - 1);

  state_t        state_q, state_d;
  op_t           op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [15:0]   data_q, data_d;
  logic [2:0]    idx_q, idx_d;
  logic          ext_q, ext_d;
  logic          rsel_q, rsel_d;
  after_t        aft_q, aft_d;
  logic          err_q, err_d;
  logic [15:0]   id0_q, id0_d, id1_q, id1_d;

  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          p_clr, p_smp, p_stable, p_last;
  step_t         step;

  nvm_seq_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  nvm_seq_poll #(.LIMIT(TMO_LIMIT)) i_poll (
    .clk(clk), .rst_n(rst_n), .clear(p_clr), .sample(p_smp),
    .bit6(fl_dq_in[6]), .stable(p_stable), .at_limit(p_last)
  );

  assign step = burst_step(op_q, idx_q, ext_q);

  // next-state process
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    addr_d  = addr_q;
    data_d  = data_q;
    idx_d   = idx_q;
    ext_d   = ext_q;
    rsel_d  = rsel_q;
    aft_d   = aft_q;
    err_d   = err_q;
    id0_d   = id0_q;
    id1_d   = id1_q;
    t_load  = 1'b0;
    t_val   = T_WLO;
    p_clr   = 1'b0;
    p_smp   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          addr_d = req_addr;
          data_d = req_wdata;
          idx_d  = '0;
          ext_d  = 1'b0;
          rsel_d = 1'b0;
          if (req_op > 3'd4) begin
            err_d   = 1'b1;
            state_d = S_RESP;
          end else begin
            op_d    = op_t'(req_op);
            state_d = S_WLO;
            t_load  = 1'b1;
            t_val   = T_WLO;
          end
        end
      end
      S_WLO: begin
        if (t_exp) begin
          state_d = S_WHI;
          t_load  = 1'b1;
          t_val   = T_WHI;
        end
      end
      S_WHI: begin
        if (t_exp) begin
          if (idx_q != last_step(op_q)) begin
            idx_d   = idx_q + 1'b1;
            state_d = S_WLO;
            t_load  = 1'b1;
            t_val   = T_WLO;
          end else begin
            idx_d = '0;
            if (op_q == OP_ID && ext_q) begin
              err_d   = 1'b0;
              state_d = S_RESP;
            end else begin
              p_clr   = 1'b1;
              rsel_d  = 1'b0;
              state_d = S_RD;
              t_load  = 1'b1;
              t_val   = T_RD;
            end
          end
        end
      end
      S_RD: begin
        if (t_exp) begin
          state_d = S_RHI;
          t_load  = 1'b1;
          t_val   = T_RHI;
          if (op_q == OP_ID) begin
            if (!rsel_q) begin
              id0_d  = fl_dq_in;
              rsel_d = 1'b1;
              aft_d  = A_READ;
            end else begin
              id1_d = fl_dq_in;
              ext_d = 1'b1;
              aft_d = A_WRITE;
            end
          end else begin
            p_smp = 1'b1;
            if (p_stable)    aft_d = A_OK;
            else if (p_last) aft_d = A_ERR;
            else             aft_d = A_READ;
          end
        end
      end
      S_RHI: begin
        if (t_exp) begin
          case (aft_q)
            A_READ: begin
              state_d = S_RD;
              t_load  = 1'b1;
              t_val   = T_RD;
            end
            A_WRITE: begin
              state_d = S_WLO;
              t_load  = 1'b1;
              t_val   = T_WLO;
            end
            A_OK: begin
              err_d   = 1'b0;
              state_d = S_RESP;
            end
            default: begin
              err_d   = 1'b1;
              state_d = S_RESP;
            end
          endcase
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      ext_q   <= 1'b0;
      rsel_q  <= 1'b0;
      aft_q   <= A_READ;
      err_q   <= 1'b0;
      id0_q   <= '0;
      id1_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      idx_q   <= idx_d;
      ext_q   <= ext_d;
      rsel_q  <= rsel_d;
      aft_q   <= aft_d;
      err_q   <= err_d;
      id0_q   <= id0_d;
      id1_q   <= id1_d;
    end
  end

  // outputs decoded from registered state
  logic wr_ph, rd_ph;
  assign wr_ph = (state_q == S_WLO) || (state_q == S_WHI);
  assign rd_ph = (state_q == S_RD)  || (state_q == S_RHI);

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_err   = err_q;
  assign rsp_id0   = id0_q;
  assign rsp_id1   = id1_q;
  assign fl_ce_n   = !(wr_ph || rd_ph);
  assign fl_we_n   = (state_q != S_WLO);
  assign fl_oe_n   = (state_q != S_RD);
  assign fl_dq_oe  = wr_ph;

  always_comb begin
    fl_addr   = '0;
    fl_dq_out = '0;
    if (wr_ph) begin
      fl_addr   = step.tgt_a ? addr_q : AW'(step.a);
      fl_dq_out = step.tgt_d ? data_q : {8'h00, step.d};
    end else if (rd_ph) begin
      fl_addr   = (op_q == OP_ID) ? AW'(rsel_q) : addr_q;
    end
  end

  // assertion-side run counter for the write-enable low phase
  logic [15:0] we_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       we_lo_run <= '0;
    else if (!fl_we_n) we_lo_run <= we_lo_run + 1'b1;
    else              we_lo_run <= '0;
  end

  // R1
  wr_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  // R1
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_lo_run >= 16'(WE_LO_CYC)));

  // R4
  rd_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_ce_n && !fl_dq_oe));

  // R4
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n && $past(!fl_oe_n)) |-> $stable(fl_addr));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op > 3'd4)) |=> (rsp_valid && rsp_err && fl_ce_n));

endmodule

// File: tb/test_nvm_cmd_sequencer.sv
module test_nvm_cmd_sequencer;

  localparam int AW   = 18;
  localparam int WLO  = 10;
  localparam int WHI  = 10;
  localparam int RDC  = 6;
  localparam int OEH  = 8;
  localparam int TMO  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic          rsp_valid, rsp_err;
  logic [15:0]   rsp_id0, rsp_id1;
  logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [15:0]   fl_dq_out;
  logic [15:0]   fl_dq_in;

  always #10 clk = ~clk;

  nvm_cmd_sequencer #(
    .AW(AW), .WE_LO_CYC(WLO), .WE_HI_CYC(WHI), .RD_CYC(RDC),
    .OE_HI_CYC(OEH), .TMO_LIMIT(TMO)
  ) i_nvm_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_id0(rsp_id0), .rsp_id1(rsp_id1),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int checks = 0;
  int errors = 0;

  // behavioural flash responder state
  int            rd_n, busy_k, wr_cnt, tviol;
  bit            id_mode, seen_rise, seen_read;
  int            we_lo, we_hi, oe_lo, oe_hi;
  logic          pw_we, pw_oe;
  logic [AW-1:0] last_a, cur_rd_a;
  logic [15:0]   last_d;
  logic [AW-1:0] wr_a [16];
  logic [15:0]   wr_d [16];
  logic [AW-1:0] rd_a [32];
  logic [AW-1:0] exp_a [16];
  logic [15:0]   exp_d [16];

  function automatic logic tog(int i, int k);
    return (i >= 1 && i <= k) ? logic'(i % 2) : 1'b0;
  endfunction

  always_comb begin
    if (id_mode) fl_dq_in = fl_addr[0] ? 16'h0092 : 16'h001F;
    else         fl_dq_in = {9'b0, tog(rd_n, busy_k), 6'b0};
  end

  always @(negedge clk) begin
    if (rst_n) begin
      // write strobe
      if (!fl_we_n) begin
        if (fl_ce_n || !fl_oe_n || !fl_dq_oe) tviol++;
        if (!pw_we && (fl_addr != last_a || fl_dq_out != last_d)) tviol++;
        if (pw_we && seen_rise && we_hi < WHI) tviol++;
        we_lo++;
        last_a = fl_addr;
        last_d = fl_dq_out;
      end else begin
        if (!pw_we) begin
          if (we_lo < WLO) tviol++;
          if (wr_cnt < 16) begin
            wr_a[wr_cnt] = last_a;
            wr_d[wr_cnt] = last_d;
          end
          wr_cnt++;
          if (last_d[7:0] == 8'h90) id_mode = 1'b1;
          if (last_d[7:0] == 8'hF0) id_mode = 1'b0;
          seen_rise = 1'b1;
          we_hi = 0;
        end
        we_lo = 0;
        we_hi++;
      end
      // read strobe
      if (!fl_oe_n) begin
        if (pw_oe) begin
          if (seen_read && oe_hi < OEH) tviol++;
          if (rd_n < 32) rd_a[rd_n] = fl_addr;
          rd_n++;
          cur_rd_a = fl_addr;
          seen_read = 1'b1;
          oe_lo = 0;
        end
        if (fl_addr != cur_rd_a || !fl_we_n) tviol++;
        oe_lo++;
      end else begin
        if (!pw_oe) begin
          if (oe_lo < RDC) tviol++;
          oe_hi = 0;
        end
        oe_hi++;
      end
      pw_we = fl_we_n;
      pw_oe = fl_oe_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [AW-1:0] a, input logic [7:0] d);
    exp_a[i] = a;
    exp_d[i] = {8'h00, d};
  endtask

  // expected write burst, built from the requirement text
  task automatic build_exp(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [15:0] d, output int n);
    n = 0;
    if (op <= 3'd4) begin
      put(0, AW'(15'h5555), 8'hAA);
      put(1, AW'(15'h2AAA), 8'h55);
    end
    case (op)
      3'd0: begin
        put(2, AW'(15'h5555), 8'hA0);
        exp_a[3] = a; exp_d[3] = d; n = 4;
      end
      3'd1, 3'd2, 3'd3: begin
        put(2, AW'(15'h5555), 8'h80);
        put(3, AW'(15'h5555), 8'hAA);
        put(4, AW'(15'h2AAA), 8'h55);
        if (op == 3'd1)      put(5, a, 8'h30);
        else if (op == 3'd2) put(5, AW'(15'h5555), 8'h10);
        else                 put(5, AW'(15'h5555), 8'h40);
        n = 6;
      end
      3'd4: begin
        put(2, AW'(15'h5555), 8'h90);
        put(3, AW'(15'h5555), 8'hAA);
        put(4, AW'(15'h2AAA), 8'h55);
        put(5, AW'(15'h5555), 8'hF0);
        n = 6;
      end
      default: n = 0;
    endcase
  endtask

  function automatic int reads_needed(int k);
    logic p, c;
    p = tog(1, k);
    for (int i = 2; i < 64; i++) begin
      c = tog(i, k);
      if (c == p) return i;
      p = c;
    end
    return 64;
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [15:0] d, input int k, input bit hold);
    int    ne, exp_rd, wait_n, need;
    bit    exp_err, rdy_seen, seq_ok;
    bit    got_err;
    logic [15:0] g0, g1;
    string rq;
    build_exp(op, a, d, ne);
    exp_err = 1'b0;
    exp_rd  = 0;
    if (op <= 3'd3) begin
      need = reads_needed(k);
      if (need - 1 > TMO) begin exp_err = 1'b1; exp_rd = TMO + 1; end
      else exp_rd = need;
    end else if (op == 3'd4) exp_rd = 2;
    else exp_err = 1'b1;
    rq = (op == 3'd0) ? "R2" : (op <= 3'd3) ? "R3" : (op == 3'd4) ? "R7" : "R9";

    @(negedge clk);
    wr_cnt = 0; rd_n = 0; seen_rise = 0; seen_read = 0; tviol = 0; busy_k = k;
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold) begin req_valid = 1'b1; req_op = 3'd2; end
    wait_n = 0; rdy_seen = 0;
    while (!rsp_valid && wait_n < 20000) begin
      if (req_ready) rdy_seen = 1'b1;
      @(negedge clk);
      wait_n++;
    end
    req_valid = 1'b0;
    got_err = rsp_err; g0 = rsp_id0; g1 = rsp_id1;
    chk(rsp_valid, "R8", "response seen", rsp_valid, 1);

    chk(wr_cnt == ne, rq, "write count", wr_cnt, ne);
    seq_ok = 1'b1;
    for (int i = 0; i < ne && i < wr_cnt; i++)
      if (wr_a[i] != exp_a[i] || wr_d[i] != exp_d[i]) begin
        if (seq_ok) chk(1'b0, rq, "write word", {wr_a[i], wr_d[i]}, {exp_a[i], exp_d[i]});
        seq_ok = 1'b0;
      end
    if (seq_ok) chk(1'b1, rq, "write words", 0, 0);

    chk(tviol == 0, "R1 R4", "strobe timing violations", tviol, 0);
    chk(rd_n == exp_rd, exp_err ? "R6" : "R5", "status read count", rd_n, exp_rd);
    chk(got_err == exp_err, exp_err ? "R6" : "R5", "error flag", got_err, exp_err);
    if (op <= 3'd3)
      for (int i = 0; i < rd_n && i < 32; i++)
        if (rd_a[i] != a) chk(1'b0, "R4", "poll address", rd_a[i], a);
    if (op == 3'd4) begin
      chk(rd_a[0] == 0 && rd_a[1] == 1, "R7", "ID read addresses", {rd_a[0], rd_a[1]}, 1);
      chk(g0 == 16'h001F && g1 == 16'h0092, "R7", "ID words", {g0, g1}, 32'h001F0092);
    end
    if (op > 3'd4) chk(wait_n == 0, "R9", "immediate response", wait_n, 0);

    @(negedge clk);
    chk(!rsp_valid && req_ready && fl_ce_n, "R8", "idle after pulse",
        {rsp_valid, req_ready, fl_ce_n}, 3'b011);
    if (hold) begin
      chk(!rdy_seen, "R8", "ready while busy", rdy_seen, 0);
      @(negedge clk);
      chk(fl_ce_n && wr_cnt == ne, "R8", "held request ignored", wr_cnt, ne);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    rd_n = 0; busy_k = 0; wr_cnt = 0; tviol = 0; id_mode = 1'b0;
    seen_rise = 1'b0; seen_read = 1'b0; we_lo = 0; we_hi = 0; oe_lo = 0; oe_hi = 0;
    pw_we = 1'b1; pw_oe = 1'b1; last_a = '0; last_d = '0; cur_rd_a = '0;
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && req_ready && !rsp_valid,
        "R10", "bus idle in reset",
        {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n && req_ready, "R10", "idle after reset",
        {fl_ce_n, fl_we_n, fl_oe_n, req_ready}, 4'b1111);

    // directed corners
    run_op(3'd0, 18'h00123, 16'hBEEF, 0, 1'b0); // R2 R5 quick finish
    run_op(3'd1, 18'h05ABC, 16'h0000, 3, 1'b0); // R3 sector
    run_op(3'd2, 18'h00000, 16'h0000, 8, 1'b0); // R6 boundary: exactly TMO compares
    run_op(3'd3, 18'h3FFFF, 16'h0000, 9, 1'b0); // R6 one past limit
    run_op(3'd4, 18'h00000, 16'h0000, 0, 1'b0); // R7
    run_op(3'd6, 18'h00010, 16'h1111, 0, 1'b0); // R9
    run_op(3'd0, 18'h1FFFF, 16'h0001, 5, 1'b1); // R8 held request

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [2:0]    rop;
      logic [AW-1:0] ra;
      logic [15:0]   rw;
      int            rk;
      rop = 3'($urandom_range(0, 7));
      ra  = AW'($urandom);
      rw  = 16'($urandom);
      rk  = $urandom_range(0, 12);
      run_op(rop, ra, rw, rk, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule